// File: doc/BRIEF.md
# Slotted Flit Assembler and Checker

This block packs fixed-size link flits. On the transmit side, slot payloads of 16 bytes arrive one at a time over a valid/ready handshake. Each payload carries a small slot-type tag. Four slots make one 528-bit flit. A 16-bit CRC over the 64 payload bytes is placed after them. When fewer than four payloads arrive before an idle timeout, the partial flit is sent anyway, and its empty slots are filled with zeros. The per-slot tags travel beside the flit on a sideband bus.

On the receive side, a 528-bit flit is taken in over a valid/ready handshake and its CRC is recomputed. A flit whose CRC matches is offered downstream as four unpacked slots, held until the consumer accepts it. A flit whose CRC does not match is discarded, and the only trace of it is a single-cycle error pulse.

Top module: `flit_slot_link`

## Requirements
- R1: A transmitted flit is 528 bits wide. Slot i occupies bits [128i+127:128i], so slot 0 sits in bytes 0 to 15. The CRC occupies bits 527:512, with CRC[7:0] in byte 64.
- R2: The CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF and no final inversion. It is computed over bytes 0 to 63 in ascending order, with each byte fed most significant bit first.
- R3: When the fourth slot payload is accepted, tx_flit_valid is high from the next cycle. The slots appear in the order they were accepted.
- R4: If FLUSH_CYCLES (default 8) consecutive cycles pass after the last accepted payload with no new payload, a partial flit is emitted. Its unfilled slots are all-zero with tag 0. Accepting a payload restarts this count.
- R5: While tx_flit_valid is high and tx_flit_ready is low, the flit and its tags stay constant and slot_ready is low, so no payload is absorbed.
- R6: The tag of slot i is presented on tx_flit_tags[4i+3:4i].
- R7: A received flit with a matching CRC is presented on rx_slots, with rx_slots_valid high from the cycle after acceptance, and rx_crc_err stays low.
- R8: A received flit with a CRC mismatch raises rx_crc_err for exactly one cycle, and rx_slots_valid stays low for it. Every single-bit error anywhere in the 528 bits is detected.
- R9: While rx_slots_valid is high and rx_slots_ready is low, rx_slots stays constant and rx_flit_ready is low.
- R10: After reset, slot_ready and rx_flit_ready are high, and tx_flit_valid, rx_slots_valid and rx_crc_err are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Slot payload offered |
| slot_ready | output | 1 | Slot payload can be taken |
| slot_data | input | 128 | Slot payload |
| slot_tag | input | 4 | Slot-type tag of the payload |
| tx_flit_valid | output | 1 | Assembled flit available |
| tx_flit_ready | input | 1 | Consumer takes the flit |
| tx_flit | output | 528 | Assembled flit with CRC |
| tx_flit_tags | output | 16 | Per-slot tags of the flit |
| rx_flit_valid | input | 1 | Received flit offered |
| rx_flit_ready | output | 1 | Received flit can be taken |
| rx_flit | input | 528 | Received flit with CRC |
| rx_slots_valid | output | 1 | Checked slots available |
| rx_slots_ready | input | 1 | Consumer takes the slots |
| rx_slots | output | 512 | Unpacked slots of a good flit |
| rx_crc_err | output | 1 | One-cycle CRC mismatch pulse |

## Verification
The bench sweeps a single flipped bit across every one of the 528 positions, including the CRC field. A checker that compared only part of the flit, or that used a wrong polynomial or byte order, would let some of these through. It times the flush exactly, one cycle before and at the deadline, and it lands a new payload on the last idle cycle to show the count restarts. A design that was off by one would emit early or late, and one that ignored the restart would flush a half-built flit. Backpressure is held on both sides while new traffic is offered, which exposes a design that overwrites a waiting flit or silently absorbs a payload it never sends. Partial flits are checked for zero filler and zero tags.

// File: rtl/flit_pkg.sv
package flit_pkg;

   localparam int CRC_W = 16;

   // One byte of CRC-16 update, byte fed MSB first.
   function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c_in,
                                                   input logic [7:0]       d,
                                                   input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] c;
      c = c_in ^ {d, 8'h00};
      for (int k = 0; k < 8; k++) begin
         c = c[CRC_W-1] ? ((c << 1) ^ poly) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/flit_crc16.sv
module flit_crc16 #(
   parameter int          NBYTES = 64,
   parameter logic [15:0] POLY   = 16'h1021,
   parameter logic [15:0] INIT   = 16'hFFFF
) (
   input  logic [NBYTES*8-1:0] data,
   output logic [15:0]         crc
);
   import flit_pkg::*;

   if (NBYTES < 1) begin : g_bad_len
      $error("flit_crc16: NBYTES must be at least 1");
   end

   always_comb begin
      logic [15:0] c;
      c = INIT;
      for (int b = 0; b < NBYTES; b++) begin
         c = crc16_byte(c, data[b*8 +: 8], POLY);
      end
      crc = c;
   end

endmodule

// File: rtl/flit_tx_packer.sv
module flit_tx_packer #(
   parameter int SLOT_W       = 128,
   parameter int NUM_SLOTS    = 4,
   parameter int TAG_W        = 4,
   parameter int FLUSH_CYCLES = 8,
   localparam int CNT_W       = $clog2(NUM_SLOTS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [SLOT_W-1:0]          in_data,
   input  logic [TAG_W-1:0]           in_tag,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [NUM_SLOTS*SLOT_W-1:0] out_slots,
   output logic [NUM_SLOTS*TAG_W-1:0]  out_tags
);

   if (NUM_SLOTS < 1 || SLOT_W < 1 || TAG_W < 1) begin : g_bad_shape
      $error("flit_tx_packer: slot count, slot width and tag width must be positive");
   end
   if (FLUSH_CYCLES < 0) begin : g_bad_flush
      $error("flit_tx_packer: FLUSH_CYCLES must not be negative");
   end

   logic             out_valid_q;
   logic [CNT_W-1:0] cnt_q;
   logic             in_fire;
   logic             pop;
   logic             flush_hit;

   assign in_ready  = !out_valid_q;
   assign in_fire   = in_valid && in_ready;
   assign pop       = out_valid_q && out_ready;
   assign out_valid = out_valid_q;

   // Idle timeout; FLUSH_CYCLES == 0 builds a variant with no partial flits.
   if (FLUSH_CYCLES > 0) begin : g_flush
      localparam int TMR_W = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;
      logic [TMR_W-1:0] timer_q;

      always_ff @(posedge clk) begin
         if (!rst_n)                     timer_q <= '0;
         else if (in_fire || out_valid_q) timer_q <= '0;
         else if (cnt_q != '0)            timer_q <= timer_q + 1'b1;
      end

      assign flush_hit = (cnt_q != '0) && !in_fire &&
                         (timer_q == TMR_W'(FLUSH_CYCLES - 1));
   end else begin : g_no_flush
      assign flush_hit = 1'b0;
   end

   // Slot storage, one register pair per slot position.
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic [SLOT_W-1:0] s_q;
      logic [TAG_W-1:0]  t_q;

      always_ff @(posedge clk) begin
         if (!rst_n || pop) begin
            s_q <= '0;
            t_q <= '0;
         end else if (in_fire && cnt_q == CNT_W'(i)) begin
            s_q <= in_data;
            t_q <= in_tag;
         end
      end

      assign out_slots[i*SLOT_W +: SLOT_W] = s_q;
      assign out_tags[i*TAG_W +: TAG_W]    = t_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         out_valid_q <= 1'b0;
      end else if (out_valid_q) begin
         if (out_ready) begin
            cnt_q       <= '0;
            out_valid_q <= 1'b0;
         end
      end else if (in_fire) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_W'(NUM_SLOTS - 1)) out_valid_q <= 1'b1;
      end else if (flush_hit) begin
         out_valid_q <= 1'b1;
      end
   end

   assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_slots) && $stable(out_tags)));

   assert_no_empty_flit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (cnt_q != '0));

   assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(NUM_SLOTS));

endmodule

// File: rtl/flit_rx_checker.sv
module flit_rx_checker #(
   parameter int PAY_W = 512,
   parameter int CRC_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [PAY_W+CRC_W-1:0] in_flit,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [PAY_W-1:0]       out_slots,
   output logic                   crc_err
);

   if (PAY_W % 8 != 0 || CRC_W != 16) begin : g_bad_shape
      $error("flit_rx_checker: payload must be whole bytes and CRC 16 bits");
   end

   logic [CRC_W-1:0] calc;
   logic             good;
   logic             in_fire;
   logic             out_valid_q;
   logic             err_q;
   logic [PAY_W-1:0] slots_q;

   flit_crc16 #(.NBYTES(PAY_W/8)) crc_i (
      .data (in_flit[PAY_W-1:0]),
      .crc  (calc)
   );

   assign good      = (calc == in_flit[PAY_W +: CRC_W]);
   assign in_ready  = !out_valid_q || out_ready;
   assign in_fire   = in_valid && in_ready;
   assign out_valid = out_valid_q;
   assign out_slots = slots_q;
   assign crc_err   = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         err_q       <= 1'b0;
         slots_q     <= '0;
      end else begin
         err_q <= in_fire && !good;
         if (in_fire) begin
            out_valid_q <= good;
            if (good) slots_q <= in_flit[PAY_W-1:0];
         end else if (out_ready) begin
            out_valid_q <= 1'b0;
         end
      end
   end

   assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_slots)));

   assert_err_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> !out_valid);

endmodule

// File: rtl/flit_slot_link.sv
module flit_slot_link #(
   parameter int SLOT_BYTES   = 16,
   parameter int NUM_SLOTS    = 4,
   parameter int TAG_W        = 4,
   parameter int FLUSH_CYCLES = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                slot_valid,
   output logic                                slot_ready,
   input  logic [SLOT_BYTES*8-1:0]             slot_data,
   input  logic [TAG_W-1:0]                    slot_tag,
   output logic                                tx_flit_valid,
   input  logic                                tx_flit_ready,
   output logic [NUM_SLOTS*SLOT_BYTES*8+15:0]  tx_flit,
   output logic [NUM_SLOTS*TAG_W-1:0]          tx_flit_tags,
   input  logic                                rx_flit_valid,
   output logic                                rx_flit_ready,
   input  logic [NUM_SLOTS*SLOT_BYTES*8+15:0]  rx_flit,
   output logic                                rx_slots_valid,
   input  logic                                rx_slots_ready,
   output logic [NUM_SLOTS*SLOT_BYTES*8-1:0]   rx_slots,
   output logic                                rx_crc_err
);
   import flit_pkg::*;

   localparam int SLOT_W = SLOT_BYTES * 8;
   localparam int PAY_W  = NUM_SLOTS * SLOT_W;

   if (SLOT_BYTES < 1 || NUM_SLOTS < 1) begin : g_bad_shape
      $error("flit_slot_link: slot size and count must be positive");
   end

   logic [PAY_W-1:0] tx_pay;
   logic [CRC_W-1:0] tx_crc;

   flit_tx_packer #(
      .SLOT_W       (SLOT_W),
      .NUM_SLOTS    (NUM_SLOTS),
      .TAG_W        (TAG_W),
      .FLUSH_CYCLES (FLUSH_CYCLES)
   ) packer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (slot_valid),
      .in_ready  (slot_ready),
      .in_data   (slot_data),
      .in_tag    (slot_tag),
      .out_valid (tx_flit_valid),
      .out_ready (tx_flit_ready),
      .out_slots (tx_pay),
      .out_tags  (tx_flit_tags)
   );

   flit_crc16 #(.NBYTES(PAY_W/8)) tx_crc_i (
      .data (tx_pay),
      .crc  (tx_crc)
   );

   assign tx_flit = {tx_crc, tx_pay};

   flit_rx_checker #(
      .PAY_W (PAY_W),
      .CRC_W (CRC_W)
   ) checker_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_flit_valid),
      .in_ready  (rx_flit_ready),
      .in_flit   (rx_flit),
      .out_valid (rx_slots_valid),
      .out_ready (rx_slots_ready),
      .out_slots (rx_slots),
      .crc_err   (rx_crc_err)
   );

endmodule

// File: tb/flit_slot_link_tb_top.sv
module flit_slot_link_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int FLUSH      = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         slot_valid = 1'b0;
   logic         slot_ready;
   logic [127:0] slot_data = '0;
   logic [3:0]   slot_tag = '0;
   logic         tx_flit_valid;
   logic         tx_flit_ready = 1'b0;
   logic [527:0] tx_flit;
   logic [15:0]  tx_flit_tags;
   logic         rx_flit_valid = 1'b0;
   logic         rx_flit_ready;
   logic [527:0] rx_flit = '0;
   logic         rx_slots_valid;
   logic         rx_slots_ready = 1'b0;
   logic [511:0] rx_slots;
   logic         rx_crc_err;

   int checks = 0;
   int errors = 0;

   logic [127:0] exp_s [4];
   logic [3:0]   exp_t [4];
   int           n_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   flit_slot_link #(.FLUSH_CYCLES(FLUSH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .slot_valid(slot_valid), .slot_ready(slot_ready),
      .slot_data(slot_data), .slot_tag(slot_tag),
      .tx_flit_valid(tx_flit_valid), .tx_flit_ready(tx_flit_ready),
      .tx_flit(tx_flit), .tx_flit_tags(tx_flit_tags),
      .rx_flit_valid(rx_flit_valid), .rx_flit_ready(rx_flit_ready),
      .rx_flit(rx_flit),
      .rx_slots_valid(rx_slots_valid), .rx_slots_ready(rx_slots_ready),
      .rx_slots(rx_slots), .rx_crc_err(rx_crc_err)
   );

   // Bit-serial reference CRC, written from R2.
   function automatic logic [15:0] ref_crc(input logic [511:0] pay);
      logic [15:0] c;
      logic        fb;
      c = 16'hFFFF;
      for (int b = 0; b < 64; b++) begin
         for (int k = 7; k >= 0; k--) begin
            fb = c[15] ^ pay[b*8 + k];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
         end
      end
      return c;
   endfunction

   function automatic logic [511:0] exp_payload();
      logic [511:0] p;
      for (int i = 0; i < 4; i++) p[i*128 +: 128] = exp_s[i];
      return p;
   endfunction

   function automatic logic [15:0] exp_tags();
      logic [15:0] t;
      for (int i = 0; i < 4; i++) t[i*4 +: 4] = exp_t[i];
      return t;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [527:0] act, input logic [527:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_exp();
      for (int i = 0; i < 4; i++) begin
         exp_s[i] = '0;
         exp_t[i] = '0;
      end
      n_exp = 0;
   endtask

   // Called at a negedge; returns at the negedge after the accepting edge.
   task automatic push(input logic [127:0] d, input logic [3:0] t);
      slot_valid = 1'b1;
      slot_data  = d;
      slot_tag   = t;
      while (!slot_ready) @(negedge clk);
      @(negedge clk);
      slot_valid = 1'b0;
      exp_s[n_exp] = d;
      exp_t[n_exp] = t;
      n_exp++;
   endtask

   task automatic check_tx(input string tag);
      logic [511:0] p;
      p = exp_payload();
      chk(tx_flit_valid == 1'b1, "R3", {tag, " flit valid"}, 528'(tx_flit_valid), 528'(1));
      chk(tx_flit[511:0] == p, "R1", {tag, " slot placement"}, 528'(tx_flit[511:0]), 528'(p));
      chk(tx_flit[527:512] == ref_crc(p), "R2", {tag, " crc field"},
          528'(tx_flit[527:512]), 528'(ref_crc(p)));
      chk(tx_flit_tags == exp_tags(), "R6", {tag, " tags"}, 528'(tx_flit_tags), 528'(exp_tags()));
   endtask

   task automatic pop_tx();
      tx_flit_ready = 1'b1;
      @(negedge clk);
      tx_flit_ready = 1'b0;
      chk(tx_flit_valid == 1'b0, "R3", "flit gone after pop", 528'(tx_flit_valid), 528'(0));
   endtask

   // Requires rx_slots empty on entry.
   task automatic rx_send(input logic [527:0] f, input bit expect_good, input string tag);
      rx_flit       = f;
      rx_flit_valid = 1'b1;
      while (!rx_flit_ready) @(negedge clk);
      @(negedge clk);
      rx_flit_valid = 1'b0;
      if (expect_good) begin
         chk(rx_slots_valid == 1'b1, "R7", {tag, " slots valid"}, 528'(rx_slots_valid), 528'(1));
         chk(rx_slots == f[511:0], "R7", {tag, " slots data"}, 528'(rx_slots), 528'(f[511:0]));
         chk(rx_crc_err == 1'b0, "R7", {tag, " no error"}, 528'(rx_crc_err), 528'(0));
         rx_slots_ready = 1'b1;
         @(negedge clk);
         rx_slots_ready = 1'b0;
         chk(rx_slots_valid == 1'b0, "R7", {tag, " slots popped"}, 528'(rx_slots_valid), 528'(0));
      end else begin
         chk(rx_crc_err == 1'b1 && rx_slots_valid == 1'b0, "R8", {tag, " detected and dropped"},
             528'({rx_crc_err, rx_slots_valid}), 528'(2'b10));
         @(negedge clk);
         chk(rx_crc_err == 1'b0, "R8", {tag, " pulse one cycle"}, 528'(rx_crc_err), 528'(0));
      end
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [527:0] good_flit(input logic [511:0] p);
      return {ref_crc(p), p};
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [527:0] held;
      logic [527:0] f1;
      logic [527:0] f2;
      logic [511:0] base;
      void'($urandom(32'h5EED_1234));

      // Reset state, R10
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(slot_ready && rx_flit_ready, "R10", "readies after reset",
          528'({slot_ready, rx_flit_ready}), 528'(2'b11));
      chk(!tx_flit_valid && !rx_slots_valid && !rx_crc_err, "R10", "valids after reset",
          528'({tx_flit_valid, rx_slots_valid, rx_crc_err}), 528'(0));

      // Bench reference sanity for R2: "123456789" gives 29B1
      begin
         logic [15:0] c;
         logic [71:0] s;
         logic        fb;
         s = "123456789";
         c = 16'hFFFF;
         for (int b = 8; b >= 0; b--) begin
            for (int k = 7; k >= 0; k--) begin
               fb = c[15] ^ s[b*8 + k];
               c  = {c[14:0], 1'b0};
               if (fb) c = c ^ 16'h1021;
            end
         end
         chk(c == 16'h29B1, "R2", "reference check value", 528'(c), 528'(16'h29B1));
      end

      // Full flit, directed pattern
      clear_exp();
      push({4{32'h0000_0001}}, 4'h1);
      push({4{32'h2222_2222}}, 4'h2);
      push({4{32'hA5A5_5A5A}}, 4'h3);
      push({4{32'hFFFF_FFFF}}, 4'hF);
      check_tx("full directed");

      // Backpressure on tx, R5
      held          = tx_flit;
      slot_valid    = 1'b1;
      slot_data     = {4{32'hDEAD_BEEF}};
      slot_tag      = 4'h7;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(slot_ready == 1'b0, "R5", "no accept while held", 528'(slot_ready), 528'(0));
         chk(tx_flit == held && tx_flit_valid, "R5", "flit stable while held", tx_flit, held);
      end
      slot_valid = 1'b0;
      pop_tx();

      // Partial flit timing and zero fill, R4; also shows stalled slot was not taken
      clear_exp();
      push({4{32'h1357_9BDF}}, 4'h9);
      push({4{32'h0F0F_F0F0}}, 4'h4);
      repeat (FLUSH - 1) @(negedge clk);
      chk(tx_flit_valid == 1'b0, "R4", "no flush one cycle early", 528'(tx_flit_valid), 528'(0));
      @(negedge clk);
      chk(tx_flit_valid == 1'b1, "R4", "flush at deadline", 528'(tx_flit_valid), 528'(1));
      chk(tx_flit[511:256] == '0 && tx_flit_tags[15:8] == '0, "R4", "zero filler and tags",
          528'({tx_flit_tags[15:8], tx_flit[511:256]}), 528'(0));
      check_tx("partial two");
      pop_tx();

      // Timer restart on late accept, R4
      clear_exp();
      push(rnd128(), 4'h5);
      repeat (FLUSH - 1) @(negedge clk);
      push(rnd128(), 4'h6);
      chk(tx_flit_valid == 1'b0, "R4", "accept restarts timeout", 528'(tx_flit_valid), 528'(0));
      repeat (FLUSH) @(negedge clk);
      check_tx("restart flush");
      pop_tx();

      // Randomized flits with loopback into the receiver
      for (int n = 0; n < 40; n++) begin
         int k;
         clear_exp();
         k = 1 + int'($urandom % 4);
         for (int s = 0; s < k; s++) push(rnd128(), 4'($urandom));
         if (k < 4) repeat (FLUSH) @(negedge clk);
         check_tx("random");
         repeat (int'($urandom % 3)) @(negedge clk);
         held = tx_flit;
         pop_tx();
         rx_send(held, 1'b1, "loopback");
      end

      // All-zero payload good flit
      rx_send(good_flit('0), 1'b1, "zero payload");

      // Receiver backpressure, R9
      f1 = good_flit({rnd128(), rnd128(), rnd128(), rnd128()});
      f2 = good_flit({rnd128(), rnd128(), rnd128(), rnd128()});
      rx_flit = f1;
      rx_flit_valid = 1'b1;
      @(negedge clk);
      rx_flit = f2;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         chk(rx_flit_ready == 1'b0, "R9", "input stalled while held", 528'(rx_flit_ready), 528'(0));
         chk(rx_slots == f1[511:0] && rx_slots_valid, "R9", "held slots stable",
             528'(rx_slots), 528'(f1[511:0]));
      end
      rx_slots_ready = 1'b1;
      @(negedge clk);
      rx_slots_ready = 1'b0;
      rx_flit_valid  = 1'b0;
      chk(rx_slots == f2[511:0] && rx_slots_valid, "R9", "next flit after release",
          528'(rx_slots), 528'(f2[511:0]));
      rx_slots_ready = 1'b1;
      @(negedge clk);
      rx_slots_ready = 1'b0;

      // Single-bit error sweep over all 528 positions, R8
      base = {rnd128(), rnd128(), rnd128(), rnd128()};
      for (int j = 0; j < 528; j++) begin
         logic [527:0] f;
         f = good_flit(base);
         f[j] = ~f[j];
         rx_send(f, 1'b0, "single bit flip");
      end
      chk(rx_slots_valid == 1'b0, "R8", "nothing delivered after sweep", 528'(rx_slots_valid), 528'(0));

      // Good flit still accepted after errors
      rx_send(good_flit(base), 1'b1, "good after errors");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule